// File: doc/BRIEF.md
# Immediate-Controlled Lane Shuffle Unit

This unit rearranges 32-bit elements held in 128-bit vector lanes. An 8-bit immediate supplies a two-bit selector for each of the four destination positions in a lane. Each selector names the source element that lands in that position. A mode input picks one of four forms:

- a single-source permute of one 128-bit vector;
- a two-source merge, in which the lower result pair comes from the first operand and the upper pair from the second;
- a 256-bit form that applies the same immediate permute inside each 128-bit lane separately;
- a 256-bit variable form that takes a separate selector for each element from a control vector.

Data never crosses a 128-bit lane boundary. The result is registered, and a valid flag is delayed by one clock to match it. The two selector patterns used for pair swap and neighbour swap allow a horizontal lane sum to be built from two shuffle-and-add passes.

Top module: `lane_shuffle_unit`

## Requirements
- R1: Mode code 0 (single source) sets result element i (bits [32i+31:32i], i = 0..3) to element k of `src_a[127:0]`, where k is immediate bits [2i+1:2i].
- R2: In mode 0, immediate 0xE4 returns the source unchanged, 0x00 copies element 0 to all four positions, and 0x4E exchanges the upper element pair with the lower pair.
- R3: Mode code 1 (two source) fills result elements 0 and 1 from `src_a[127:0]` and elements 2 and 3 from `src_b[127:0]`, each indexed by its own immediate field.
- R4: In modes 0 and 1 the result bits [255:128] are zero.
- R5: Mode code 2 (wide, immediate) permutes each 128-bit half of `src_a` independently using the same four immediate fields, indexing only within that half.
- R6: Mode code 3 (wide, variable) takes the selector for result element j (j = 0..7) from bits [32j+1:32j] of `ctrl`. The selector indexes within element j's own 128-bit lane, the other 30 bits of each control element are ignored, and the immediate has no effect.
- R7: `out_valid` equals `in_valid` delayed by one clock. `result` is loaded only when `in_valid` is high, using the mode, immediate and operands present in that cycle, and it holds otherwise.
- R8: While `rst` is high, `out_valid` and `result` are cleared to zero on the clock edge.
- R9: Shuffling a vector with 0x4E, adding element-wise, then shuffling the sum with 0xB1 and adding again, leaves the 32-bit wrapped sum of all four elements in every element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands, mode and immediate are valid this cycle |
| mode | input | 2 | 0 single, 1 two-source, 2 wide immediate, 3 wide variable |
| imm | input | 8 | Four two-bit selector fields |
| src_a | input | 256 | First operand (low 128 bits in modes 0 and 1) |
| src_b | input | 256 | Second operand (low 128 bits used in mode 1) |
| ctrl | input | 256 | Per-element selectors for mode 3 |
| out_valid | output | 1 | Result valid |
| result | output | 256 | Registered shuffled vector |

## Verification
The hardest case to reach is a wrong-lane or wrong-source pick that is hidden by repeated operand values. To expose it, every element of every operand is given a distinct value, so any misrouted element shows up. All 256 immediates are swept in each immediate-driven mode. The variable mode is driven with control words whose upper 30 bits are pseudo-random and whose selectors differ per element, with a conflicting immediate applied at the same time. Hold behaviour is checked by changing all inputs while `in_valid` is low.

// File: rtl/shuffle_pkg.sv
package shuffle_pkg;
  typedef enum logic [1:0] {
    SHF_SINGLE   = 2'd0,
    SHF_PAIR     = 2'd1,
    SHF_WIDE_IMM = 2'd2,
    SHF_WIDE_VAR = 2'd3
  } shf_mode_e;
endpackage

// File: rtl/lane_permute.sv
// One 128-bit lane: lower destination half picks from lo_src, upper half from hi_src.
module lane_permute #(
  parameter int ELEM_W     = 32,
  parameter int LANE_ELEMS = 4,
  localparam int SEL_W     = $clog2(LANE_ELEMS),
  localparam int LANE_W    = ELEM_W * LANE_ELEMS
) (
  input  logic [LANE_W-1:0]           lo_src,
  input  logic [LANE_W-1:0]           hi_src,
  input  logic [LANE_ELEMS*SEL_W-1:0] sels,
  output logic [LANE_W-1:0]           dst
);
  for (genvar e = 0; e < LANE_ELEMS; e++) begin : g_elem
    logic [LANE_W-1:0] src;
    logic [ELEM_W-1:0] pick;
    if (e < LANE_ELEMS / 2) begin : g_lo
      assign src = lo_src;
    end else begin : g_hi
      assign src = hi_src;
    end
    always_comb begin
      pick = '0;
      for (int k = 0; k < LANE_ELEMS; k++)
        if (sels[e*SEL_W +: SEL_W] == SEL_W'(k))
          pick = src[k*ELEM_W +: ELEM_W];
    end
    assign dst[e*ELEM_W +: ELEM_W] = pick;
  end
endmodule

// File: rtl/sel_gen.sv
// Produces per-lane selector fields from the immediate or from the control vector.
module sel_gen #(
  parameter int ELEM_W     = 32,
  parameter int LANE_ELEMS = 4,
  parameter int NUM_LANES  = 2,
  localparam int SEL_W     = $clog2(LANE_ELEMS),
  localparam int IMM_W     = LANE_ELEMS * SEL_W,
  localparam int VEC_W     = ELEM_W * LANE_ELEMS * NUM_LANES
) (
  input  logic                       use_ctrl,
  input  logic [IMM_W-1:0]           imm,
  input  logic [VEC_W-1:0]           ctrl,
  output logic [NUM_LANES*IMM_W-1:0] lane_sels
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    for (genvar e = 0; e < LANE_ELEMS; e++) begin : g_elem
      localparam int J = l * LANE_ELEMS + e;
      assign lane_sels[J*SEL_W +: SEL_W] =
        use_ctrl ? ctrl[J*ELEM_W +: SEL_W] : imm[e*SEL_W +: SEL_W];
    end
  end
endmodule

// File: rtl/lane_shuffle_unit.sv
module lane_shuffle_unit
  import shuffle_pkg::*;
#(
  parameter int ELEM_W     = 32,
  parameter int LANE_ELEMS = 4,
  parameter int NUM_LANES  = 2,
  localparam int SEL_W     = $clog2(LANE_ELEMS),
  localparam int IMM_W     = LANE_ELEMS * SEL_W,
  localparam int LANE_W    = ELEM_W * LANE_ELEMS,
  localparam int VEC_W     = LANE_W * NUM_LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       mode,
  input  logic [IMM_W-1:0] imm,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] ctrl,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);
  shf_mode_e mode_e;
  logic      narrow;
  logic [NUM_LANES*IMM_W-1:0] lane_sels;
  logic [VEC_W-1:0]           next_res;

  assign mode_e = shf_mode_e'(mode);
  assign narrow = (mode_e == SHF_SINGLE) || (mode_e == SHF_PAIR);

  sel_gen #(.ELEM_W(ELEM_W), .LANE_ELEMS(LANE_ELEMS), .NUM_LANES(NUM_LANES)) i_sel (
    .use_ctrl (mode_e == SHF_WIDE_VAR),
    .imm      (imm),
    .ctrl     (ctrl),
    .lane_sels(lane_sels)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] hi_src;
    logic [LANE_W-1:0] dst;
    if (l == 0) begin : g_first
      assign hi_src = (mode_e == SHF_PAIR) ? src_b[LANE_W-1:0] : src_a[LANE_W-1:0];
      assign next_res[LANE_W-1:0] = dst;
    end else begin : g_upper
      assign hi_src = src_a[l*LANE_W +: LANE_W];
      assign next_res[l*LANE_W +: LANE_W] = narrow ? '0 : dst;
    end
    lane_permute #(.ELEM_W(ELEM_W), .LANE_ELEMS(LANE_ELEMS)) i_perm (
      .lo_src(src_a[l*LANE_W +: LANE_W]),
      .hi_src(hi_src),
      .sels  (lane_sels[l*IMM_W +: IMM_W]),
      .dst   (dst)
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  // Valid timing
  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_fall_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  // Narrow modes leave the upper lanes zero
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (mode == 2'd0 || mode == 2'd1)) |=> (result[VEC_W-1:LANE_W] == '0));
  // Identity immediate
  assert_identity_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'd0 && imm == 8'hE4) |=> (result[LANE_W-1:0] == $past(src_a[LANE_W-1:0])));
  // Broadcast immediate
  assert_broadcast_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'd0 && imm == 8'h00) |=>
      (result[ELEM_W-1:0] == $past(src_a[ELEM_W-1:0]) &&
       result[LANE_W-1:LANE_W-ELEM_W] == $past(src_a[ELEM_W-1:0])));
endmodule

// File: tb/test_lane_shuffle_unit.sv
module test_lane_shuffle_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [1:0]   mode;
  logic [7:0]   imm;
  logic [255:0] src_a, src_b, ctrl;
  logic         out_valid;
  logic [255:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  lane_shuffle_unit i_lane_shuffle_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .imm(imm),
    .src_a(src_a), .src_b(src_b), .ctrl(ctrl),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  // Expected value built directly from the requirement text
  function automatic logic [255:0] expect_res(input logic [1:0] m, input logic [7:0] im,
      input logic [255:0] a, input logic [255:0] b, input logic [255:0] c);
    logic [255:0] r = '0;
    for (int j = 0; j < 8; j++) begin
      int lane = j / 4;
      int e = j % 4;
      int idx;
      if (m <= 2'd1) begin
        if (lane == 0) begin
          idx = int'(im[2*e +: 2]);
          if (m == 2'd1 && e >= 2) r[32*j +: 32] = b[32*idx +: 32];
          else                     r[32*j +: 32] = a[32*idx +: 32];
        end
      end else begin
        if (m == 2'd2) idx = int'(im[2*e +: 2]);
        else           idx = int'(c[32*j +: 2]);
        r[32*j +: 32] = a[128*lane + 32*idx +: 32];
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fill_operands();
    for (int k = 0; k < 8; k++) begin
      seed = lcg(seed);
      src_a[32*k +: 32] = {seed[31:8], 8'(k)};
      seed = lcg(seed);
      src_b[32*k +: 32] = {seed[31:8], 8'(k + 8'h10)};
    end
  endtask

  task automatic apply(input logic [1:0] m, input logic [7:0] im);
    @(negedge clk);
    mode = m; imm = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_check(input string req, input logic [1:0] m, input logic [7:0] im);
    logic [255:0] e;
    e = expect_res(m, im, src_a, src_b, ctrl);
    apply(m, im);
    chk(req, result, e);
    chk({req, " valid R7"}, {255'd0, out_valid}, 256'd1);
  endtask

  initial begin
    logic [255:0] held, e, v, s1, s2;
    logic [31:0] tot;
    rst = 1'b1; in_valid = 1'b0; mode = '0; imm = '0;
    src_a = '0; src_b = '0; ctrl = '0;
    repeat (3) @(negedge clk);
    chk("R8 reset result", result, '0);
    chk("R8 reset valid", {255'd0, out_valid}, '0);
    rst = 1'b0;

    // R1, R4: single-source mode over every immediate
    for (int i = 0; i < 256; i++) begin
      fill_operands();
      run_check("R1/R4 single", 2'd0, 8'(i));
    end
    // R2: named patterns
    fill_operands();
    run_check("R2 identity", 2'd0, 8'hE4);
    chk("R2 identity literal", result, {128'd0, src_a[127:0]});
    run_check("R2 broadcast", 2'd0, 8'h00);
    chk("R2 broadcast literal", result, {128'd0, {4{src_a[31:0]}}});
    run_check("R2 swap", 2'd0, 8'h4E);
    chk("R2 swap literal", result, {128'd0, src_a[63:0], src_a[127:64]});
    // R3: two-source mode over every immediate
    for (int i = 0; i < 256; i++) begin
      fill_operands();
      run_check("R3/R4 pair", 2'd1, 8'(i));
    end
    // R5: wide immediate over every immediate
    for (int i = 0; i < 256; i++) begin
      fill_operands();
      run_check("R5 wide imm", 2'd2, 8'(i));
    end
    // R6: variable control, random upper bits, conflicting immediate
    for (int i = 0; i < 64; i++) begin
      fill_operands();
      for (int k = 0; k < 8; k++) begin
        seed = lcg(seed);
        ctrl[32*k +: 32] = seed;
      end
      run_check("R6 wide var", 2'd3, 8'(~i));
    end
    // R7: hold while in_valid low
    held = result;
    fill_operands();
    @(negedge clk); mode = 2'd2; imm = 8'h1B;
    @(negedge clk);
    chk("R7 hold result", result, held);
    chk("R7 hold valid", {255'd0, out_valid}, '0);

    // R9: horizontal lane sum via two shuffle-add passes
    for (int t = 0; t < 16; t++) begin
      fill_operands();
      v = src_a;
      tot = v[31:0] + v[63:32] + v[95:64] + v[127:96];
      apply(2'd0, 8'h4E);
      s1 = '0;
      for (int k = 0; k < 4; k++) s1[32*k +: 32] = v[32*k +: 32] + result[32*k +: 32];
      src_a = s1;
      apply(2'd0, 8'hB1);
      s2 = '0;
      for (int k = 0; k < 4; k++) s2[32*k +: 32] = s1[32*k +: 32] + result[32*k +: 32];
      e = {128'd0, {4{tot}}};
      chk("R9 horizontal sum", s2, e);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule